// File: doc/BRIEF.md
# Single-Register I2C Read Master

This block reads one 8-bit register from a slave on an I2C bus. A host raises a request together with a register sub-address. The block then runs one complete read frame on the bus and hands back the byte. Only one register is touched per frame, and the slave is assumed not to auto-increment.

The frame has a fixed order:
- START, then the slave address byte with the write direction.
- The sub-address, then a repeated START.
- The slave address byte with the read direction.
- One data byte received from the slave, answered with a NACK.
- STOP.

A single free-running divider splits every SCL bit period into four timed points: mid-high, end of high, mid-low and end of period. Every action on the bus happens at one of these points.

The host sees an idle flag and a completion pulse one clock wide. If the slave fails to acknowledge any address or sub-address byte, the block abandons the rest of the frame and sends STOP. It still gives the completion pulse, this time with an error flag.

SDA is open drain. The block only ever pulls it low through `sda_oe`, and it reads the wired bus level on `sda_in`.

Top module: `i2c_reg_reader`

## Requirements
- R1: The SCL period is DIV = CLK_HZ/SCL_HZ system clocks. SCL is high for counts 0..DIV/2-1 of the divider and low for the rest. While no frame is running, SCL stays high and `sda_oe` is 0.
- R2: A request is taken only on a 0-to-1 transition of `rd_req`. `idle` falls on the clock after that transition and rises when the frame completes. A level held high does not start another frame, and a new edge while a frame is pending or running is ignored.
- R3: The bus carries, in order: START, byte ADDR_WR (default 0x40), the sub-address, repeated START, byte ADDR_RD (default 0x41), one data byte, STOP. Every byte is sent most significant bit first.
- R4: Outside START and STOP, SDA changes only while SCL is low. START is SDA falling while SCL is high; STOP is SDA rising while SCL is high.
- R5: During each slave acknowledge slot, during the received data bits and during the ninth slot after the data byte, `sda_oe` is 0. The master therefore answers the data byte with a NACK (SDA high).
- R6: Data bits are sampled at the centre of the SCL high phase. The assembled byte appears on `rd_data` when `done` pulses.
- R7: `done` is high for exactly one clock. It follows the STOP at the end of that SCL high phase, and `idle` is already 1 in that cycle.
- R8: If the slave leaves SDA high in the acknowledge slot of ADDR_WR, of the sub-address or of ADDR_RD, the master sends no further byte and no repeated START, and issues STOP. `done` then pulses with `nack_err` = 1, and `rd_data` keeps its previous value. A frame that completes normally sets `nack_err` to 0.
- R9: The sub-address is captured at the accepting edge of `rd_req`. Later changes on `reg_addr` do not affect the running frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, acted on at its rising edge |
| reg_addr | input | 8 | Register sub-address to read |
| rd_data | output | 8 | Byte returned by the last successful read |
| idle | output | 1 | High when no read is pending or running |
| done | output | 1 | One-clock completion pulse |
| nack_err | output | 1 | Set when the last frame was cut short by a missing acknowledge |
| scl | output | 1 | I2C clock |
| sda_in | input | 1 | Wired level of the SDA line |
| sda_oe | output | 1 | Pull SDA low when 1, release it when 0 |

## Verification
The assertions assume several things about the bus:
- `sda_in` is the true wired level, including the master's own pull-down.
- The slave never stretches SCL.
- The slave never drives SDA in a slot the master owns.
- Request edges never land in the exact cycle of completion.

The bench's slave model respects all of these. It changes its SDA pull only after it has seen SCL fall, and it acknowledges or withholds acknowledgement per byte under test control. Requests are issued while the block is idle. Busy-time requests are placed many bit periods away from the end of the frame.

// File: rtl/i2c_reg_reader.sv
module i2c_reg_reader #(
  parameter int          CLK_HZ  = 50_000_000,
  parameter int          SCL_HZ  = 100_000,
  parameter logic [7:0]  ADDR_WR = 8'h40,
  parameter logic [7:0]  ADDR_RD = 8'h41
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_req,
  input  logic [7:0] reg_addr,
  output logic [7:0] rd_data,
  output logic       idle,
  output logic       done,
  output logic       nack_err,
  output logic       scl,
  input  logic       sda_in,
  output logic       sda_oe
);
  localparam int DIV = CLK_HZ / SCL_HZ;
  localparam int CW  = $clog2(DIV);
  localparam logic [CW-1:0] T_HI   = CW'(DIV/4 - 1);
  localparam logic [CW-1:0] T_FALL = CW'(DIV/2 - 1);
  localparam logic [CW-1:0] T_LO   = CW'(3*DIV/4 - 1);
  localparam logic [CW-1:0] T_END  = CW'(DIV - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_RSTART, S_RX, S_STOP} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic         req_q, pending, nak;
  logic [7:0]   sub_q, sh;
  logic [3:0]   bitn;
  logic [1:0]   sel;

  wire at_hi   = (cnt == T_HI);
  wire at_fall = (cnt == T_FALL);
  wire at_lo   = (cnt == T_LO);
  wire finish  = (st == S_STOP) && at_fall;

  assign scl  = (st == S_IDLE) || (cnt <= T_FALL);
  assign idle = ~pending;

  always_ff @(posedge clk)
    if (!rst_n) cnt <= '0;
    else        cnt <= (cnt == T_END) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      req_q <= 1'b0; pending <= 1'b0; sub_q <= '0;
    end else begin
      req_q <= rd_req;
      if (finish) pending <= 1'b0;
      else if (rd_req && !req_q && !pending) begin
        pending <= 1'b1;
        sub_q   <= reg_addr;
      end
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      st <= S_IDLE; sda_oe <= 1'b0; sh <= '0; bitn <= '0; sel <= '0;
      nak <= 1'b0; done <= 1'b0; nack_err <= 1'b0; rd_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (pending && at_hi) begin
            st <= S_START; sda_oe <= 1'b1; nak <= 1'b0;
          end
        S_START:
          if (at_lo) begin
            sh <= ADDR_WR; sda_oe <= ~ADDR_WR[7]; bitn <= '0; sel <= 2'd0; st <= S_TX;
          end
        S_TX: begin
          if (at_hi && bitn == 4'd8) nak <= sda_in;
          if (at_lo) begin
            if (bitn < 4'd7) begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; bitn <= bitn + 1'b1;
            end else if (bitn == 4'd7) begin
              sda_oe <= 1'b0; bitn <= 4'd8;
            end else if (nak) begin
              sda_oe <= 1'b1; st <= S_STOP;
            end else begin
              case (sel)
                2'd0: begin
                  sh <= sub_q; sda_oe <= ~sub_q[7]; bitn <= '0; sel <= 2'd1;
                end
                2'd1: begin sda_oe <= 1'b0; st <= S_RSTART; end
                default: begin sda_oe <= 1'b0; bitn <= '0; st <= S_RX; end
              endcase
            end
          end
        end
        S_RSTART: begin
          if (at_hi) sda_oe <= 1'b1;
          if (at_lo) begin
            sh <= ADDR_RD; sda_oe <= ~ADDR_RD[7]; bitn <= '0; sel <= 2'd2; st <= S_TX;
          end
        end
        S_RX: begin
          if (at_hi && bitn < 4'd8) sh <= {sh[6:0], sda_in};
          if (at_lo) begin
            if (bitn < 4'd8) bitn <= bitn + 1'b1;
            else begin sda_oe <= 1'b1; st <= S_STOP; end
          end
        end
        S_STOP: begin
          if (at_hi) sda_oe <= 1'b0;
          if (at_fall) begin
            st <= S_IDLE; done <= 1'b1; nack_err <= nak;
            if (!nak) rd_data <= sh;
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (scl && !sda_oe));

  p_idle_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (st == S_IDLE));

  p_sda_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_TX || st == S_RX) && scl && $past(scl)) |-> $stable(sda_oe));

  p_release_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_TX && bitn == 4'd8) || st == S_RX) |-> !sda_oe);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle);
endmodule

// File: tb/sim_i2c_reg_reader.sv
module sim_i2c_reg_reader;
  localparam int CLK_HZ = 4_000_000;
  localparam int SCL_HZ = 100_000;
  localparam int DIV    = CLK_HZ / SCL_HZ;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, rd_req;
  logic [7:0] reg_addr, rd_data;
  logic       idle, done, nack_err, scl, sda_oe;
  logic       slave_pull;
  wire        sda_bus = !(sda_oe || slave_pull);

  i2c_reg_reader #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .reg_addr(reg_addr),
    .rd_data(rd_data), .idle(idle), .done(done), .nack_err(nack_err),
    .scl(scl), .sda_in(sda_bus), .sda_oe(sda_oe));

  int vectors = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] regval(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'hC3;
  endfunction

  // divider reference: count of clocks since reset, modulo DIV
  int tc;
  always @(posedge clk)
    if (!rst_n) tc <= 0;
    else        tc <= (tc == DIV-1) ? 0 : tc + 1;

  // behavioural slave: logs bus events, acks bytes, returns data
  int  tokens[$];
  int  phase, bitn, tbit, byte_idx, nak_at, mack;
  bit  prev_scl, prev_sda, acked;
  logic [7:0] sh, last_byte, data_out;
  always @(negedge clk) begin
    if (!rst_n) begin
      slave_pull = 0; phase = 0; prev_scl = 1; prev_sda = 1;
    end else begin
      if (scl && prev_scl && prev_sda && !sda_bus) begin
        tokens.push_back(256); phase = 1; bitn = 0; sh = 0;
      end else if (scl && prev_scl && !prev_sda && sda_bus) begin
        tokens.push_back(257); phase = 0; slave_pull = 0;
      end else if (scl && !prev_scl) begin
        if (phase == 1 && bitn < 8) begin sh = {sh[6:0], sda_bus}; bitn++; end
        else if (phase == 3) tbit++;
        else if (phase == 4) begin mack = sda_bus; phase = 0; end
      end else if (!scl && prev_scl) begin
        if (phase == 1 && bitn == 8) begin
          tokens.push_back(int'(sh));
          acked = (byte_idx != nak_at);
          if (byte_idx == 1) data_out = regval(sh);
          byte_idx++;
          last_byte = sh; slave_pull = acked; phase = 2;
        end else if (phase == 2) begin
          slave_pull = 0;
          if (!acked) phase = 0;
          else if (last_byte == 8'h41) begin phase = 3; tbit = 0; slave_pull = !data_out[7]; end
          else begin phase = 1; bitn = 0; end
        end else if (phase == 3) begin
          if (tbit < 8) slave_pull = !data_out[7-tbit];
          else begin slave_pull = 0; phase = 4; end
        end
      end
      prev_scl = scl; prev_sda = sda_bus;
    end
  end

  // per-clock checks
  bit prev_done;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(!(idle && (!scl || sda_oe)), "R1", {scl, sda_oe}, 2'b10);
      chk(scl || tc >= DIV/2, "R1", tc, DIV/2);
      chk(!(done && prev_done), "R7", done, 0);
      chk(!done || idle, "R7", idle, 1);
    end
    prev_done = done;
  end

  // mode 0: pulse; 1: pulse plus a second pulse while busy; 2: hold high
  task automatic do_read(input logic [7:0] sub, input int nk, input int mode);
    int exp[$];
    logic [7:0] old;
    bit got;
    old = rd_data;
    tokens.delete(); byte_idx = 0; nak_at = nk; mack = -1;
    @(negedge clk); rd_req = 1; reg_addr = sub;
    @(negedge clk);
    if (mode != 2) rd_req = 0;
    reg_addr = ~sub;                                   // R9: change after accept
    chk(!idle, "R2", idle, 0);
    got = 0;
    for (int i = 0; i < 60*DIV; i++) begin
      if (mode == 1 && i == 5*DIV) rd_req = 1;
      if (mode == 1 && i == 5*DIV + 1) rd_req = 0;
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R7", got, 1);
    if (nk < 0) begin
      chk(nack_err == 0, "R8", nack_err, 0);
      chk(rd_data == regval(sub), "R6", rd_data, regval(sub));
      chk(mack == 1, "R5", mack, 1);
    end else begin
      chk(nack_err == 1, "R8", nack_err, 1);
      chk(rd_data == old, "R8", rd_data, old);
    end
    for (int i = 0; i < 3*DIV; i++) @(negedge clk);
    chk(idle, "R2", idle, 1);
    exp.push_back(256); exp.push_back(8'h40);
    if (nk != 0) begin
      exp.push_back(int'(sub));
      if (nk != 1) begin exp.push_back(256); exp.push_back(8'h41); end
    end
    exp.push_back(257);
    chk(tokens.size() == exp.size(), "R3", tokens.size(), exp.size());
    foreach (exp[k])
      if (k < tokens.size()) chk(tokens[k] == exp[k], (nk < 0) ? "R3" : "R8", tokens[k], exp[k]);
    rd_req = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; rd_req = 0; reg_addr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(idle && scl && !sda_oe && !done, "R1", {idle, scl, sda_oe, done}, 4'b1100);
    do_read(8'h2C, -1, 0);
    do_read(8'hF1, -1, 0);
    do_read(8'h00, -1, 0);
    do_read(8'hFF, -1, 0);
    do_read(8'h5A, 0, 0);       // R8 on write address
    do_read(8'h5A, 1, 0);       // R8 on sub-address
    do_read(8'h5A, 2, 0);       // R8 on read address
    do_read(8'h96, -1, 0);      // clean frame after errors clears flag
    do_read(8'h3B, -1, 1);      // R2 busy edge ignored
    do_read(8'hC4, -1, 2);      // R2 held level starts one frame only
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      errors++; vectors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule